// File: doc/BRIEF.md
# Acquisition Run Sequencer

This block steers one recording run of a multichannel waveform digitizer. A run may begin from a front-panel start pulse or from a software start command. It may end from a front-panel stop pulse, from a software stop command, or, when that mode is chosen, on its own once the shared sample-address counter passes the top of memory. While a run is active the block drives a run level and advances one memory address per clock. All channels write at that common address.

When a run ends, a conversion-done flag is set and stays set until software clears it. An optional one-cycle interrupt pulse marks the moment the flag is set. Three mode bits choose the behaviour:

- **Restart-from-zero:** whether each start clears the address counter. When it is off, the counter carries over between runs, so several events can be stacked in one buffer.
- **Stop-on-overrun:** whether an overrun ends the run.
- **Interrupt enable:** whether the interrupt pulse is produced.

The counter can always be read after a stop, so it also serves as a time stamp of the stop moment.

The controller has two states, `ST_IDLE` and `ST_RUN`. It has three transitions:

- **launch** (`ST_IDLE` to `ST_RUN`): a start request with no stop request in the same cycle.
- **halt** (`ST_RUN` to `ST_IDLE`): a stop request.
- **overrun halt** (`ST_RUN` to `ST_IDLE`): stop-on-overrun is set and the counter is at its top value.

All other cases hold the current state. A start request seen in `ST_RUN` is dropped.

Top module: `acq_sequencer`

## Requirements
- R1: The pin inputs `start_pin` and `stop_pin` pass through a 2-stage synchronizer and act only on a low-to-high change. A rise of `start_pin` before clock edge 1 makes `run` high after edge 3. A pin held high does not start a second run.
- R2: A one-cycle `sw_start` pulse in the idle state makes `run` high after the next clock edge.
- R3: A stop request (`sw_stop` pulse or `stop_pin` rise) in the run state makes `run` low after the edge that sees it. If start and stop requests arrive in the same idle cycle, no run begins. A stop while idle changes nothing.
- R4: On every clock edge where `run` is high, `addr` advances by one, modulo 2^ADDR_W. While `run` is low, `addr` holds its value.
- R5: With `mode_restart` = 1, an accepted start sets `addr` to 0. With `mode_restart` = 0, an accepted start leaves `addr` unchanged, so recording resumes where it stopped.
- R6: With `mode_stop_ovf` = 1, the edge that advances `addr` from 2^ADDR_W-1 also ends the run, and `addr` then reads 0. With `mode_stop_ovf` = 0, `addr` wraps to 0 and `run` stays high.
- R7: `done` goes high on the edge where `run` falls, whatever the cause. It stays high until an edge sees `sw_clr_done`. If a fall of `run` and `sw_clr_done` meet on the same edge, `done` is set.
- R8: `irq` is high for exactly the one cycle in which `done` has just risen, and only if `mode_irq_en` was 1 at that edge.
- R9: A start request while `run` is high is ignored: `addr` keeps advancing and is not cleared.
- R10: After reset, `run`, `done` and `irq` are 0 and `addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling-domain clock |
| rst_n | input | 1 | Active-low reset |
| start_pin | input | 1 | Asynchronous front-panel start pulse |
| stop_pin | input | 1 | Asynchronous front-panel stop pulse |
| sw_start | input | 1 | Synchronous one-cycle software start |
| sw_stop | input | 1 | Synchronous one-cycle software stop |
| sw_clr_done | input | 1 | Synchronous one-cycle clear of `done` |
| mode_restart | input | 1 | 1: each start clears the address counter |
| mode_stop_ovf | input | 1 | 1: counter overrun ends the run |
| mode_irq_en | input | 1 | 1: pulse `irq` when `done` is set |
| run | output | 1 | High while recording |
| done | output | 1 | Conversion-done flag |
| irq | output | 1 | One-cycle interrupt pulse |
| addr | output | ADDR_W | Shared memory write address |

## Verification
If the controller state goes wrong, `run` shows it at once, and `addr` shows it within one edge: it either freezes while it should count, or counts while `run` is low. A wrong counter start value or a missed clear appears in the first `addr` sample after a launch. A wrong overrun decision is seen exactly one cycle after `addr` reaches its top value: either `run` stays high, or it falls with the wrong mode set. Errors in the done flag or the interrupt show up on the edge where `run` falls, and then on every later cycle until the next clear.

// File: rtl/acq_pkg.sv
package acq_pkg;

    // Controller states of the run sequencer
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } acq_state_t;

    localparam int unsigned PIN_COUNT = 2;
    localparam int unsigned PIN_START = 0;
    localparam int unsigned PIN_STOP  = 1;

endpackage

// File: rtl/acq_edge_sync.sv
// Synchronizes one asynchronous pin and flags its rising edge (one cycle).
module acq_edge_sync #(
    parameter int unsigned STAGES = 2   // must be 2 or more
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/acq_addr_counter.sv
// Shared sample-address counter: synchronous clear, advance with natural wrap.
module acq_addr_counter #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              at_top
);

    localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clear) begin
            addr_q <= '0;
        end else if (advance) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr   = addr_q;
    assign at_top = (addr_q == ADDR_TOP);

endmodule

// File: rtl/acq_ctrl_fsm.sv
// Run controller: state register, transition/output decode, done and irq flags.
module acq_ctrl_fsm
    import acq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    input  logic at_top,
    input  logic mode_stop_ovf,
    input  logic mode_irq_en,
    input  logic clr_done,
    output logic run,
    output logic launch,
    output logic done,
    output logic irq
);

    acq_state_t state_q, state_d;
    logic       run_end;
    logic       done_q, irq_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition and output decode
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        run_end = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req && !stop_req) begin
                    state_d = ST_RUN;
                    launch  = 1'b1;
                end
            end
            ST_RUN: begin
                if (stop_req || (mode_stop_ovf && at_top)) begin
                    state_d = ST_IDLE;
                    run_end = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Done flag (set wins over clear) and interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (run_end) begin
                done_q <= 1'b1;
            end else if (clr_done) begin
                done_q <= 1'b0;
            end
            irq_q <= run_end & ~done_q & mode_irq_en;
        end
    end

    assign run  = (state_q == ST_RUN);
    assign done = done_q;
    assign irq  = irq_q;

endmodule

// File: rtl/acq_sequencer.sv
// Top: acquisition run sequencer.
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pin,
    input  logic              stop_pin,
    input  logic              sw_start,
    input  logic              sw_stop,
    input  logic              sw_clr_done,
    input  logic              mode_restart,
    input  logic              mode_stop_ovf,
    input  logic              mode_irq_en,
    output logic              run,
    output logic              done,
    output logic              irq,
    output logic [ADDR_W-1:0] addr
);

    logic [PIN_COUNT-1:0] pin_vec;
    logic [PIN_COUNT-1:0] pin_rise;
    logic                 start_req, stop_req;
    logic                 launch, at_top;

    assign pin_vec[PIN_START] = start_pin;
    assign pin_vec[PIN_STOP]  = stop_pin;

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        acq_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_vec[g]),
            .rise (pin_rise[g])
        );
    end

    assign start_req = pin_rise[PIN_START] | sw_start;
    assign stop_req  = pin_rise[PIN_STOP]  | sw_stop;

    acq_ctrl_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .stop_req     (stop_req),
        .at_top       (at_top),
        .mode_stop_ovf(mode_stop_ovf),
        .mode_irq_en  (mode_irq_en),
        .clr_done     (sw_clr_done),
        .run          (run),
        .launch       (launch),
        .done         (done),
        .irq          (irq)
    );

    acq_addr_counter #(
        .ADDR_W(ADDR_W)
    ) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch & mode_restart),
        .advance(run),
        .addr   (addr),
        .at_top (at_top)
    );

endmodule

// File: rtl/acq_sequencer_chk.sv
// Port-level checker for acq_sequencer, bound below.
module acq_sequencer_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_clr_done,
    input logic              mode_stop_ovf,
    input logic              mode_irq_en,
    input logic              run,
    input logic              done,
    input logic              irq,
    input logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (addr == ADDR_W'($past(addr) + 1'b1)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> $stable(addr));

    // R6
    ovf_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_stop_ovf && addr == TOP) |=> !run);

    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> done);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(run));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sw_clr_done) |=> done);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($rose(done) && $past(mode_irq_en)));

endmodule

bind acq_sequencer acq_sequencer_chk #(.ADDR_W(ADDR_W)) i_acq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_clr_done  (sw_clr_done),
    .mode_stop_ovf(mode_stop_ovf),
    .mode_irq_en  (mode_irq_en),
    .run          (run),
    .done         (done),
    .irq          (irq),
    .addr         (addr)
);

// File: tb/test_acq_sequencer.sv
module test_acq_sequencer;

    localparam int unsigned ADDR_W = 10;
    localparam int          DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_pin = 1'b0, stop_pin = 1'b0;
    logic sw_start = 1'b0, sw_stop = 1'b0, sw_clr_done = 1'b0;
    logic mode_restart = 1'b0, mode_stop_ovf = 1'b0, mode_irq_en = 1'b0;
    logic run, done, irq;
    logic [ADDR_W-1:0] addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    acq_sequencer #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_acq_sequencer (
        .clk(clk), .rst_n(rst_n),
        .start_pin(start_pin), .stop_pin(stop_pin),
        .sw_start(sw_start), .sw_stop(sw_stop), .sw_clr_done(sw_clr_done),
        .mode_restart(mode_restart), .mode_stop_ovf(mode_stop_ovf),
        .mode_irq_en(mode_irq_en),
        .run(run), .done(done), .irq(irq), .addr(addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int exp_addr;
        tick(3);
        // R10 reset state
        chk(run == 0, "R10 run", int'(run), 0);
        chk(done == 0 && irq == 0, "R10 done/irq", int'({done, irq}), 0);
        chk(addr == 0, "R10 addr", int'(addr), 0);
        rst_n = 1'b1;
        tick(2);

        // R2 software start with restart mode, R5 clear
        mode_restart = 1'b1; mode_irq_en = 1'b1;
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        chk(run == 1, "R2 run after sw_start", int'(run), 1);
        chk(addr == 0, "R5 restart clears", int'(addr), 0);
        tick(5);
        chk(addr == 5, "R4 advance", int'(addr), 5);

        // R9 start while running ignored
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        chk(run == 1 && addr == 6, "R9 start ignored", int'(addr), 6);

        // R3 software stop, R7 done, R8 irq
        sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
        chk(run == 0, "R3 sw stop", int'(run), 0);
        chk(addr == 7, "R4 stop edge advance", int'(addr), 7);
        chk(done == 1, "R7 done set", int'(done), 1);
        chk(irq == 1, "R8 irq pulse", int'(irq), 1);
        tick(1);
        chk(irq == 0, "R8 irq one cycle", int'(irq), 0);
        tick(4);
        chk(addr == 7, "R4 idle hold", int'(addr), 7);
        chk(done == 1, "R7 done held", int'(done), 1);
        sw_clr_done = 1'b1; tick(1); sw_clr_done = 1'b0;
        chk(done == 0, "R7 done cleared", int'(done), 0);

        // R5 resume without restart; R3 stop by pin
        mode_restart = 1'b0;
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        chk(run == 1 && addr == 7, "R5 resume", int'(addr), 7);
        tick(3);
        stop_pin = 1'b1; tick(3);
        chk(run == 0, "R3 pin stop", int'(run), 0);
        chk(addr == 13, "R3 pin stop addr", int'(addr), 13);
        stop_pin = 1'b0; tick(2);

        // R1 pin start latency and level-held pin
        start_pin = 1'b1; tick(2);
        chk(run == 0, "R1 not yet", int'(run), 0);
        tick(1);
        chk(run == 1, "R1 pin start", int'(run), 1);
        chk(addr == 13, "R5 pin start no clear", int'(addr), 13);
        sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
        tick(5);
        chk(run == 0, "R1 held pin no restart", int'(run), 0);
        start_pin = 1'b0; tick(2);

        // R3 simultaneous start/stop while idle, stop while idle
        sw_clr_done = 1'b1; tick(1); sw_clr_done = 1'b0;
        sw_start = 1'b1; sw_stop = 1'b1; tick(1); sw_start = 1'b0; sw_stop = 1'b0;
        chk(run == 0, "R3 stop wins", int'(run), 0);
        chk(addr == 14 && done == 0, "R3 idle stop no effect", int'(addr), 14);

        // R7 set wins over clear
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        tick(2);
        sw_stop = 1'b1; sw_clr_done = 1'b1; tick(1); sw_stop = 1'b0; sw_clr_done = 1'b0;
        chk(done == 1, "R7 set wins", int'(done), 1);
        sw_clr_done = 1'b1; tick(1); sw_clr_done = 1'b0;

        // R6 full sweep with stop-on-overrun, irq disabled
        mode_restart = 1'b1; mode_stop_ovf = 1'b1; mode_irq_en = 1'b0;
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            chk(run == 1 && addr == k, "R6 sweep addr", int'(addr), k);
            tick(1);
        end
        chk(run == 0, "R6 overrun stop", int'(run), 0);
        chk(addr == 0, "R6 overrun addr", int'(addr), 0);
        chk(done == 1, "R7 done on overrun", int'(done), 1);
        chk(irq == 0, "R8 irq disabled", int'(irq), 0);
        sw_clr_done = 1'b1; tick(1); sw_clr_done = 1'b0;

        // R6 wrap with stop-on-overrun off
        mode_stop_ovf = 1'b0;
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        for (int k = 0; k < DEPTH + 4; k++) begin
            exp_addr = k % DEPTH;
            chk(run == 1 && addr == exp_addr, "R6 wrap addr", int'(addr), exp_addr);
            tick(1);
        end
        sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
        chk(run == 0 && addr == 5, "R3 stop after wrap", int'(addr), 5);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule